// File: doc/BRIEF.md
# Missed-Load Replay Scheduler

This block holds loads that missed in the data cache and sends them back into load stage 0 for another attempt. No load data is kept per entry. A load is reissued from the queue once one of two things happens: its own delay counter runs out, or the miss handler announces refill data for the miss id that the entry recorded. A replay request has the highest priority at stage 0. While a replay is pending, none of the other stage-0 requesters is granted.

When several entries are ready, the one enqueued earliest goes first, whatever slot it sits in. A replayed load stays in flight until its stage-2 response comes back. A hit frees the slot. A miss re-arms the slot with the new miss id and a full delay.

Uncached loads do not use the entries. Their result is held in one dedicated register and written back on writeback port 0 only. Writeback port 1 is never driven valid.

Top module: `rls_replay_sched`

## Requirements
- R1: An enqueue is accepted only while `enq_ready_o` is high. It takes the lowest-numbered free slot, and `enq_ready_o` is low exactly when all `N_ENT` slots are occupied.
- R2: With no refill, an enqueued load raises `replay_valid_o` exactly `DELAY` clock edges after the edge that accepted it (`DELAY` >= 1).
- R3: A refill whose miss id equals a waiting entry's id makes that entry ready at the next edge. A refill with any other id has no effect on it.
- R4: When a refill wakeup and a counter expiry hit an entry at the same edge, the entry is replayed once only.
- R5: `s0_other_gnt_o` is all zero while `replay_valid_o` is high or `s0_ready_i` is low. Otherwise it grants the lowest-index bit set in `s0_other_req_i`.
- R6: Among ready entries, the one enqueued earliest is offered first on `replay_idx_o`/`replay_tag_o`, independent of slot number.
- R7: A replay offer is held while `s0_ready_i` is low. It is accepted at an edge where both `replay_valid_o` and `s0_ready_i` are high, and the accepted entry is then not offered again until its response returns.
- R8: A response with `resp_hit_i`=1 frees slot `resp_idx_i`. With `resp_hit_i`=0 the slot waits again, under the id `resp_miss_id_i` and a fresh `DELAY`.
- R9: An uncached response is captured only while `unc_ready_o` is high. It is then shown on writeback port 0 until `wb0_ready_i` is high, and `unc_ready_o` stays low while it is held.
- R10: `wb1_valid_o` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue a missed load |
| enq_tag_i | input | TAG_W | Load identifier |
| enq_miss_id_i | input | MID_W | Miss-handler id of the miss |
| enq_ready_o | output | 1 | A slot is free |
| refill_valid_i | input | 1 | Miss handler received refill data |
| refill_miss_id_i | input | MID_W | Id of the refilled miss |
| s0_ready_i | input | 1 | Stage 0 accepts a request this cycle |
| s0_other_req_i | input | N_SRC | Other stage-0 requesters |
| s0_other_gnt_o | output | N_SRC | Grants to the other requesters |
| replay_valid_o | output | 1 | Replay request into stage 0 |
| replay_idx_o | output | log2(N_ENT) | Slot of the offered replay |
| replay_tag_o | output | TAG_W | Load identifier of the offered replay |
| resp_valid_i | input | 1 | Result of a replayed load |
| resp_idx_i | input | log2(N_ENT) | Slot the result belongs to |
| resp_hit_i | input | 1 | Replayed load hit |
| resp_miss_id_i | input | MID_W | New miss id on a miss |
| unc_valid_i | input | 1 | Uncached response valid |
| unc_tag_i | input | TAG_W | Uncached load identifier |
| unc_data_i | input | DATA_W | Uncached load data |
| unc_ready_o | output | 1 | Uncached register empty |
| wb0_valid_o | output | 1 | Writeback port 0 valid |
| wb0_tag_o | output | TAG_W | Writeback port 0 identifier |
| wb0_data_o | output | DATA_W | Writeback port 0 data |
| wb0_ready_i | input | 1 | Writeback port 0 accepted |
| wb1_valid_o | output | 1 | Writeback port 1 valid, held low |
| wb1_tag_o | output | TAG_W | Writeback port 1 identifier, zero |
| wb1_data_o | output | DATA_W | Writeback port 1 data, zero |

## Verification
A slot stuck in a wrong state makes the replay timing shift: `replay_valid_o` rises one or more edges early or late against the `DELAY` count. It can also show as a second replay of a load already in flight. A corrupted age relation shows up at the first moment two entries are ready together, because the scoreboard then sees identifiers fire out of enqueue order. A stale uncached register is visible on port 0 data in the cycle after a capture is refused or a release is missed.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    E_FREE   = 2'd0,
    E_WAIT   = 2'd1,
    E_READY  = 2'd2,
    E_FLIGHT = 2'd3
  } ent_state_e;
endpackage

// File: rtl/rls_entry.sv
module rls_entry
  import rls_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int MID_W = 3,
  parameter int DELAY = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic [MID_W-1:0] alloc_mid_i,
  input  logic             refill_valid_i,
  input  logic [MID_W-1:0] refill_mid_i,
  input  logic             fire_i,
  input  logic             resp_i,
  input  logic             resp_hit_i,
  input  logic [MID_W-1:0] resp_mid_i,
  output logic             busy_o,
  output logic             ready_o,
  output logic [TAG_W-1:0] tag_o
);
  ent_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic [MID_W-1:0] mid_q;
  logic             wake;

  // refill and expiry collapse into one transition
  assign wake = (refill_valid_i && refill_mid_i == mid_q) || cnt_q <= CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_FREE;
      cnt_q   <= '0;
      tag_q   <= '0;
      mid_q   <= '0;
    end else begin
      unique case (state_q)
        E_FREE: if (alloc_i) begin
          state_q <= E_WAIT;
          cnt_q   <= CNT_W'(DELAY);
          tag_q   <= alloc_tag_i;
          mid_q   <= alloc_mid_i;
        end
        E_WAIT: begin
          if (wake) state_q <= E_READY;
          else      cnt_q   <= cnt_q - CNT_W'(1);
        end
        E_READY: if (fire_i) state_q <= E_FLIGHT;
        E_FLIGHT: if (resp_i) begin
          if (resp_hit_i) begin
            state_q <= E_FREE;
          end else begin
            state_q <= E_WAIT;
            cnt_q   <= CNT_W'(DELAY);
            mid_q   <= resp_mid_i;
          end
        end
        default: state_q <= E_FREE;
      endcase
    end
  end

  assign busy_o  = state_q != E_FREE;
  assign ready_o = state_q == E_READY;
  assign tag_o   = tag_q;
endmodule

// File: rtl/rls_age_arb.sv
module rls_age_arb #(
  parameter int N_ENT = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic [N_ENT-1:0] busy_i,
  input  logic [N_ENT-1:0] req_i,
  output logic [N_ENT-1:0] gnt_oh_o
);
  // older_q[i][j] set: entry j was enqueued before entry i
  logic [N_ENT-1:0] older_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) older_q[i] <= '0;
    end else if (alloc_i) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (alloc_idx_i == IDX_W'(i)) older_q[i] <= busy_i;
        else                          older_q[i][alloc_idx_i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_sel
    assign gnt_oh_o[g] = req_i[g] && ((req_i & older_q[g]) == '0);
  end
endmodule

// File: rtl/rls_s0_arb.sv
module rls_s0_arb #(
  parameter int N_SRC = 3
) (
  input  logic             replay_req_i,
  input  logic             s0_ready_i,
  input  logic [N_SRC-1:0] other_req_i,
  output logic [N_SRC-1:0] other_gnt_o,
  output logic             replay_fire_o
);
  logic taken;

  always_comb begin
    other_gnt_o = '0;
    taken       = replay_req_i || !s0_ready_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (other_req_i[i] && !taken) begin
        other_gnt_o[i] = 1'b1;
        taken          = 1'b1;
      end
    end
  end

  assign replay_fire_o = replay_req_i && s0_ready_i;
endmodule

// File: rtl/rls_unc_buf.sv
module rls_unc_buf #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic              vld_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (!vld_q) begin
      if (in_valid_i) begin
        vld_q  <= 1'b1;
        tag_q  <= in_tag_i;
        data_q <= in_data_i;
      end
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign in_ready_o  = !vld_q;
  assign out_valid_o = vld_q;
  assign out_tag_o   = tag_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/rls_replay_sched.sv
module rls_replay_sched #(
  parameter int N_ENT  = 4,
  parameter int TAG_W  = 6,
  parameter int MID_W  = 3,
  parameter int DATA_W = 64,
  parameter int DELAY  = 4,
  parameter int N_SRC  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enq_valid_i,
  input  logic [TAG_W-1:0]         enq_tag_i,
  input  logic [MID_W-1:0]         enq_miss_id_i,
  output logic                     enq_ready_o,
  input  logic                     refill_valid_i,
  input  logic [MID_W-1:0]         refill_miss_id_i,
  input  logic                     s0_ready_i,
  input  logic [N_SRC-1:0]         s0_other_req_i,
  output logic [N_SRC-1:0]         s0_other_gnt_o,
  output logic                     replay_valid_o,
  output logic [$clog2(N_ENT)-1:0] replay_idx_o,
  output logic [TAG_W-1:0]         replay_tag_o,
  input  logic                     resp_valid_i,
  input  logic [$clog2(N_ENT)-1:0] resp_idx_i,
  input  logic                     resp_hit_i,
  input  logic [MID_W-1:0]         resp_miss_id_i,
  input  logic                     unc_valid_i,
  input  logic [TAG_W-1:0]         unc_tag_i,
  input  logic [DATA_W-1:0]        unc_data_i,
  output logic                     unc_ready_o,
  output logic                     wb0_valid_o,
  output logic [TAG_W-1:0]         wb0_tag_o,
  output logic [DATA_W-1:0]        wb0_data_o,
  input  logic                     wb0_ready_i,
  output logic                     wb1_valid_o,
  output logic [TAG_W-1:0]         wb1_tag_o,
  output logic [DATA_W-1:0]        wb1_data_o
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int CNT_W = $clog2(DELAY + 1);

  logic [N_ENT-1:0] busy, ready, gnt_oh;
  logic [TAG_W-1:0] ent_tag [N_ENT];
  logic [IDX_W-1:0] free_idx, gnt_idx;
  logic             free_found, alloc, replay_fire;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!busy[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign enq_ready_o = free_found;
  assign alloc       = enq_valid_i && free_found;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rls_entry #(
      .TAG_W(TAG_W), .MID_W(MID_W), .DELAY(DELAY), .CNT_W(CNT_W)
    ) u_ent (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .alloc_i        (alloc && free_idx == IDX_W'(g)),
      .alloc_tag_i    (enq_tag_i),
      .alloc_mid_i    (enq_miss_id_i),
      .refill_valid_i (refill_valid_i),
      .refill_mid_i   (refill_miss_id_i),
      .fire_i         (replay_fire && gnt_oh[g]),
      .resp_i         (resp_valid_i && resp_idx_i == IDX_W'(g)),
      .resp_hit_i     (resp_hit_i),
      .resp_mid_i     (resp_miss_id_i),
      .busy_o         (busy[g]),
      .ready_o        (ready[g]),
      .tag_o          (ent_tag[g])
    );
  end

  rls_age_arb #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .alloc_idx_i (free_idx),
    .busy_i      (busy),
    .req_i       (ready),
    .gnt_oh_o    (gnt_oh)
  );

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N_ENT; i++) if (gnt_oh[i]) gnt_idx = IDX_W'(i);
  end

  assign replay_valid_o = |ready;
  assign replay_idx_o   = gnt_idx;
  assign replay_tag_o   = ent_tag[gnt_idx];

  rls_s0_arb #(.N_SRC(N_SRC)) u_s0 (
    .replay_req_i  (replay_valid_o),
    .s0_ready_i    (s0_ready_i),
    .other_req_i   (s0_other_req_i),
    .other_gnt_o   (s0_other_gnt_o),
    .replay_fire_o (replay_fire)
  );

  rls_unc_buf #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_unc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (unc_valid_i),
    .in_tag_i    (unc_tag_i),
    .in_data_i   (unc_data_i),
    .in_ready_o  (unc_ready_o),
    .out_valid_o (wb0_valid_o),
    .out_tag_o   (wb0_tag_o),
    .out_data_o  (wb0_data_o),
    .out_ready_i (wb0_ready_i)
  );

  assign wb1_valid_o = 1'b0;
  assign wb1_tag_o   = '0;
  assign wb1_data_o  = '0;
endmodule

// File: rtl/rls_replay_sched_chk.sv
module rls_replay_sched_chk #(
  parameter int N_SRC  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              replay_valid_o,
  input logic              s0_ready_i,
  input logic [N_SRC-1:0]  s0_other_gnt_o,
  input logic              unc_valid_i,
  input logic              unc_ready_o,
  input logic              wb0_valid_o,
  input logic              wb0_ready_i,
  input logic [TAG_W-1:0]  wb0_tag_o,
  input logic [DATA_W-1:0] wb0_data_o
);
  p_replay_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |-> s0_other_gnt_o == '0);

  p_gnt_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s0_other_gnt_o));

  p_gnt_needs_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_other_gnt_o != '0) |-> s0_ready_i);

  p_replay_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o && !s0_ready_i |=> replay_valid_o);

  p_unc_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_valid_i && unc_ready_o |=> wb0_valid_o);

  p_wb_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb0_valid_o && !wb0_ready_i |=> wb0_valid_o && $stable(wb0_data_o) && $stable(wb0_tag_o));
endmodule

bind rls_replay_sched rls_replay_sched_chk #(
  .N_SRC(N_SRC), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .replay_valid_o (replay_valid_o),
  .s0_ready_i     (s0_ready_i),
  .s0_other_gnt_o (s0_other_gnt_o),
  .unc_valid_i    (unc_valid_i),
  .unc_ready_o    (unc_ready_o),
  .wb0_valid_o    (wb0_valid_o),
  .wb0_ready_i    (wb0_ready_i),
  .wb0_tag_o      (wb0_tag_o),
  .wb0_data_o     (wb0_data_o)
);

// File: tb/rls_replay_sched_tb.sv
module rls_replay_sched_tb;
  localparam int N_ENT = 4, TAG_W = 6, MID_W = 3, DATA_W = 64, DELAY = 4, N_SRC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, refill_valid = 0, s0_ready = 0, resp_valid = 0, resp_hit = 0;
  logic unc_valid = 0, wb0_ready = 0;
  logic [TAG_W-1:0] enq_tag = 0, unc_tag = 0;
  logic [MID_W-1:0] enq_mid = 0, refill_mid = 0, resp_mid = 0;
  logic [N_SRC-1:0] other_req = 0;
  logic [1:0] resp_idx = 0;
  logic [DATA_W-1:0] unc_data = 0;
  logic enq_ready, replay_valid, unc_ready, wb0_valid, wb1_valid;
  logic [N_SRC-1:0] other_gnt;
  logic [1:0] replay_idx;
  logic [TAG_W-1:0] replay_tag, wb0_tag, wb1_tag;
  logic [DATA_W-1:0] wb0_data, wb1_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [TAG_W-1:0] exp_q [$];

  always #5 clk = ~clk;

  rls_replay_sched #(.N_ENT(N_ENT), .TAG_W(TAG_W), .MID_W(MID_W), .DATA_W(DATA_W),
                     .DELAY(DELAY), .N_SRC(N_SRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_tag_i(enq_tag), .enq_miss_id_i(enq_mid), .enq_ready_o(enq_ready),
    .refill_valid_i(refill_valid), .refill_miss_id_i(refill_mid),
    .s0_ready_i(s0_ready), .s0_other_req_i(other_req), .s0_other_gnt_o(other_gnt),
    .replay_valid_o(replay_valid), .replay_idx_o(replay_idx), .replay_tag_o(replay_tag),
    .resp_valid_i(resp_valid), .resp_idx_i(resp_idx), .resp_hit_i(resp_hit), .resp_miss_id_i(resp_mid),
    .unc_valid_i(unc_valid), .unc_tag_i(unc_tag), .unc_data_i(unc_data), .unc_ready_o(unc_ready),
    .wb0_valid_o(wb0_valid), .wb0_tag_o(wb0_tag), .wb0_data_o(wb0_data), .wb0_ready_i(wb0_ready),
    .wb1_valid_o(wb1_valid), .wb1_tag_o(wb1_tag), .wb1_data_o(wb1_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enq(input logic [TAG_W-1:0] t, input logic [MID_W-1:0] m);
    enq_valid = 1; enq_tag = t; enq_mid = m;
    cyc(1);
    enq_valid = 0;
  endtask

  task automatic refill(input logic [MID_W-1:0] m);
    refill_valid = 1; refill_mid = m;
    cyc(1);
    refill_valid = 0;
  endtask

  // driver: expected identifier goes to the scoreboard before stage 0 takes it
  task automatic accept(input logic [TAG_W-1:0] t);
    exp_q.push_back(t);
    s0_ready = 1;
    cyc(1);
    s0_ready = 0;
  endtask

  task automatic resp(input logic [1:0] idx, input logic hit, input logic [MID_W-1:0] m);
    resp_valid = 1; resp_idx = idx; resp_hit = hit; resp_mid = m;
    cyc(1);
    resp_valid = 0;
  endtask

  // monitor: every replay taken by stage 0 must match the scoreboard head (R6)
  always @(negedge clk) begin
    if (rst_n && replay_valid && s0_ready) begin
      if (exp_q.size() == 0) chk("R6 unexpected replay", {58'd0, replay_tag}, 64'hFFFF);
      else chk("R6 replay order", {58'd0, replay_tag}, {58'd0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset enq_ready", enq_ready, 1);
    chk("R2 reset replay_valid", replay_valid, 0);
    chk("R9 reset wb0_valid", wb0_valid, 0);
    chk("R10 reset wb1_valid", wb1_valid, 0);
    rst_n = 1;
    cyc(1);

    // R2 delay expiry, R5 priority, R7 hold
    enq(6'd5, 3'd1);
    chk("R2 not ready yet", replay_valid, 0);
    cyc(3);
    chk("R2 one edge early", replay_valid, 0);
    other_req = 3'b111;
    cyc(1);
    chk("R2 ready after DELAY", replay_valid, 1);
    chk("R1 lowest free slot", replay_idx, 0);
    chk("R5 no grant without s0_ready", other_gnt, 0);
    cyc(2);
    chk("R7 held while stalled", replay_valid, 1);
    s0_ready = 1; #1;
    chk("R5 replay outranks others", other_gnt, 0);
    s0_ready = 0;
    accept(6'd5);
    chk("R7 not offered while in flight", replay_valid, 0);
    other_req = 3'b110; s0_ready = 1; #1;
    chk("R5 lowest other granted", other_gnt, 3'b010);
    s0_ready = 0; other_req = 0;
    resp(2'd0, 1'b1, 3'd0);
    chk("R8 hit frees slot", enq_ready, 1);

    // R3 refill wakeup
    enq(6'd9, 3'd2);
    refill(3'd3);
    chk("R3 other id ignored", replay_valid, 0);
    refill(3'd2);
    chk("R3 matching id wakes", replay_valid, 1);
    accept(6'd9);
    resp(2'd0, 1'b1, 3'd0);

    // R4 refill and expiry at the same edge
    enq(6'd11, 3'd4);
    cyc(3);
    chk("R4 before coincident edge", replay_valid, 0);
    refill(3'd4);
    chk("R4 ready", replay_valid, 1);
    accept(6'd11);
    chk("R4 single replay", replay_valid, 0);
    cyc(5);
    chk("R4 no second replay", replay_valid, 0);
    resp(2'd0, 1'b1, 3'd0);

    // R8 miss re-arms with new id
    enq(6'd20, 3'd1);
    refill(3'd1);
    accept(6'd20);
    resp(2'd0, 1'b0, 3'd5);
    refill(3'd1);
    chk("R8 old id no longer wakes", replay_valid, 0);
    refill(3'd5);
    chk("R8 new id wakes", replay_valid, 1);
    accept(6'd20);
    resp(2'd0, 1'b1, 3'd0);

    // R6 age order across slot numbers, R1 full
    enq(6'd30, 3'd0);
    enq(6'd31, 3'd1);
    refill(3'd0);
    chk("R6 single ready slot", replay_idx, 0);
    accept(6'd30);
    resp(2'd0, 1'b1, 3'd0);
    enq(6'd32, 3'd2);
    enq(6'd33, 3'd3);
    enq(6'd34, 3'd4);
    chk("R1 full", enq_ready, 0);
    cyc(5);
    chk("R6 oldest slot first", replay_idx, 1);
    chk("R6 oldest tag first", replay_tag, 6'd31);
    exp_q.push_back(6'd31); exp_q.push_back(6'd32);
    exp_q.push_back(6'd33); exp_q.push_back(6'd34);
    s0_ready = 1;
    cyc(4);
    s0_ready = 0;
    chk("R6 all drained", exp_q.size(), 0);
    chk("R7 none offered after drain", replay_valid, 0);
    resp(2'd1, 1'b1, 3'd0);
    resp(2'd0, 1'b1, 3'd0);
    resp(2'd2, 1'b1, 3'd0);
    resp(2'd3, 1'b1, 3'd0);
    chk("R1 free again", enq_ready, 1);

    // R9 uncached register, R10 port 1
    unc_valid = 1; unc_tag = 6'd7; unc_data = 64'hABCD;
    cyc(1);
    unc_valid = 0;
    chk("R9 captured valid", wb0_valid, 1);
    chk("R9 captured data", wb0_data, 64'hABCD);
    chk("R9 captured tag", wb0_tag, 6'd7);
    chk("R9 ready low while held", unc_ready, 0);
    unc_valid = 1; unc_tag = 6'd9; unc_data = 64'h1111;
    cyc(1);
    unc_valid = 0;
    chk("R9 second response ignored", wb0_data, 64'hABCD);
    chk("R10 port 1 idle", wb1_valid, 0);
    wb0_ready = 1;
    cyc(1);
    wb0_ready = 0;
    chk("R9 released", wb0_valid, 0);
    chk("R9 ready again", unc_ready, 1);
    unc_valid = 1; unc_tag = 6'd3; unc_data = 64'h5555;
    cyc(1);
    unc_valid = 0;
    chk("R9 new data", wb0_data, 64'h5555);
    chk("R10 port 1 still idle", wb1_valid, 0);

    finish_run();
  end
endmodule